// File: doc/BRIEF.md
# Segment Selector Address Translator

This block converts a logical address into a 32-bit linear address. The logical address is a 16-bit segment selector plus a 32-bit offset. The selector names a slot in one of two descriptor tables: a global one and a local one. The base and limit of each table arrive as 48-bit register inputs. The block forms the address of the 8-byte descriptor and first checks that the whole descriptor lies inside the chosen table. It then reads the descriptor as two 32-bit words over a simple request/valid memory port. It checks the offset against the segment limit held in the descriptor. It returns either base plus offset or a fault code.

A one-cycle `start` pulse begins a translation. The result comes back with a one-cycle `done` pulse. The linear address, the fault code and the requested privilege level taken from the selector stay on the outputs until the next result. While `busy` is high, the block drops any further start pulses. A memory agent answers each one-cycle `mem_req` with a single `mem_rvalid` beat one or more cycles later.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits [1:0] are the requested privilege level and appear on `rpl_out` with every result. Bit [2] chooses the table. Bits [15:3] are the descriptor index.
- R2: Selector bit [2] = 0 uses `gdt_reg` and bit [2] = 1 uses `ldt_reg`. In each table register, bits [15:0] are the table limit and bits [47:16] are the table base.
- R3: The descriptor address is the table base plus index × 8. The block reads word 0 at that address and then word 1 at that address + 4. Word 0 bits [15:0] hold the segment limit. Word 1 holds the segment base.
- R4: If index × 8 + 7 is greater than the table limit, `done` rises in the cycle after start with `fault` = 1 and `lin_addr` = 0, and no `mem_req` is issued.
- R5: If the offset is greater than the segment limit, the result has `fault` = 2 and `lin_addr` = 0. An offset equal to the limit is allowed.
- R6: Otherwise the result is `fault` = 0 and `lin_addr` = segment base + offset, modulo 2^32.
- R7: A start pulse that arrives while `busy` is high is ignored. It produces no result and does not change the result of the translation already in progress.
- R8: `done` and `mem_req` are each high for exactly one cycle at a time. A second request is not issued until the first has received `mem_rvalid`.
- R9: After reset, `done`, `mem_req` and `busy` are 0, and `fault` and `lin_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a translation |
| selector | input | 16 | Segment selector |
| offset | input | 32 | Effective offset within the segment |
| gdt_reg | input | 48 | Global table: base [47:16], limit [15:0] |
| ldt_reg | input | 48 | Local table: base [47:16], limit [15:0] |
| mem_req | output | 1 | One-cycle descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result pulse |
| lin_addr | output | 32 | Linear address, 0 on a fault |
| fault | output | 2 | 0 none, 1 table bound, 2 segment limit |
| rpl_out | output | 2 | Requested privilege level of the result |
| busy | output | 1 | Translation in progress |

## Verification
The in-line assertions check on every cycle that `done` and `mem_req` are single-cycle pulses and that a table overrun completes one cycle after start without a read. They also check that a segment overrun zeroes the address and that a start during busy never returns the block to idle without a result. Only the bench scenarios can show that the arithmetic is right. That covers the choice between the global and local tables, the descriptor address, the order and spacing of the two reads, the sum of base and offset with wrap-around, and the exact boundary cases at both limits. The bench checks these against its own memory image, with read latencies that vary.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  parameter int unsigned SEL_W   = 16;
  parameter int unsigned ADDR_W  = 32;
  parameter int unsigned LIM_W   = 16;
  parameter int unsigned DESC_SH = 3;              // log2 of descriptor bytes
  localparam int unsigned IDX_W  = SEL_W - 3;
  localparam int unsigned TREG_W = ADDR_W + LIM_W;
  localparam int unsigned WORD_B = 4;              // bytes per fetched word

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_TABLE = 2'd1,
    FLT_SEG   = 2'd2
  } fault_e;

  // descriptor location inside its table
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] tbase,
                                                  input logic [IDX_W-1:0] idx);
    logic [ADDR_W-1:0] scaled;
    scaled = ADDR_W'(idx) << DESC_SH;
    return tbase + scaled;
  endfunction

  // last byte of the slot must not pass the table limit
  function automatic logic slot_outside(input logic [IDX_W-1:0] idx,
                                        input logic [LIM_W-1:0] tlim);
    logic [ADDR_W-1:0] last_b;
    last_b = (ADDR_W'(idx) << DESC_SH) + ADDR_W'((1 << DESC_SH) - 1);
    return last_b > ADDR_W'(tlim);
  endfunction

  function automatic logic off_outside(input logic [ADDR_W-1:0] off,
                                       input logic [LIM_W-1:0] slim);
    return off > ADDR_W'(slim);
  endfunction
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_xlate_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [TREG_W-1:0] gtab,
  input  logic [TREG_W-1:0] ltab,
  output logic [1:0]        rpl,
  output logic [ADDR_W-1:0] slot,
  output logic              tab_overrun
);
  logic              use_local;
  logic [IDX_W-1:0]  idx;
  logic [TREG_W-1:0] tab;
  logic [ADDR_W-1:0] tbase;
  logic [LIM_W-1:0]  tlim;

  assign rpl       = sel[1:0];
  assign use_local = sel[2];
  assign idx       = sel[SEL_W-1:3];
  assign tab       = use_local ? ltab : gtab;
  assign tbase     = tab[TREG_W-1:LIM_W];
  assign tlim      = tab[LIM_W-1:0];

  assign slot        = slot_addr(tbase, idx);
  assign tab_overrun = slot_outside(idx, tlim);
endmodule

// File: rtl/seg_limit_add.sv
module seg_limit_add
  import seg_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] off,
  input  logic [ADDR_W-1:0] word_lo,
  input  logic [ADDR_W-1:0] word_hi,
  output logic [ADDR_W-1:0] lin,
  output logic              seg_overrun
);
  logic [LIM_W-1:0] slim;

  assign slim        = word_lo[LIM_W-1:0];
  assign seg_overrun = off_outside(off, slim);
  assign lin         = word_hi + off;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SEL_W-1:0]    selector,
  input  logic [ADDR_W-1:0]   offset,
  input  logic [TREG_W-1:0]   gdt_reg,
  input  logic [TREG_W-1:0]   ldt_reg,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [ADDR_W-1:0]   mem_rdata,
  output logic                done,
  output logic [ADDR_W-1:0]   lin_addr,
  output logic [1:0]          fault,
  output logic [1:0]          rpl_out,
  output logic                busy
);
  typedef enum logic [2:0] {S_IDLE, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1} st_e;

  st_e               st;
  logic [ADDR_W-1:0] off_q, slot_q, w0_q, lin_q;
  logic [1:0]        rpl_hold, rpl_q;
  fault_e            flt_q;
  logic              done_q;

  logic [1:0]        dec_rpl;
  logic [ADDR_W-1:0] dec_slot, add_lin;
  logic              dec_overrun, add_overrun;

  // named events for the assertions
  logic start_acc, tab_fault_ev, seg_fault_ev, fin_ev;

  seg_sel_decode u_dec (
    .sel(selector), .gtab(gdt_reg), .ltab(ldt_reg),
    .rpl(dec_rpl), .slot(dec_slot), .tab_overrun(dec_overrun)
  );

  seg_limit_add u_add (
    .off(off_q), .word_lo(w0_q), .word_hi(mem_rdata),
    .lin(add_lin), .seg_overrun(add_overrun)
  );

  assign start_acc    = start && (st == S_IDLE);
  assign tab_fault_ev = start_acc && dec_overrun;
  assign fin_ev       = (st == S_WAIT1) && mem_rvalid;
  assign seg_fault_ev = fin_ev && add_overrun;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      off_q    <= '0;
      slot_q   <= '0;
      w0_q     <= '0;
      lin_q    <= '0;
      rpl_hold <= '0;
      rpl_q    <= '0;
      flt_q    <= FLT_NONE;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (start_acc) begin
          off_q    <= offset;
          slot_q   <= dec_slot;
          rpl_hold <= dec_rpl;
          if (dec_overrun) begin
            done_q <= 1'b1;
            flt_q  <= FLT_TABLE;
            lin_q  <= '0;
            rpl_q  <= dec_rpl;
          end else begin
            st <= S_REQ0;
          end
        end
        S_REQ0:  st <= S_WAIT0;
        S_WAIT0: if (mem_rvalid) begin
          w0_q <= mem_rdata;
          st   <= S_REQ1;
        end
        S_REQ1:  st <= S_WAIT1;
        S_WAIT1: if (mem_rvalid) begin
          done_q <= 1'b1;
          flt_q  <= add_overrun ? FLT_SEG : FLT_NONE;
          lin_q  <= add_overrun ? '0 : add_lin;
          rpl_q  <= rpl_hold;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_REQ0) || (st == S_REQ1);
  assign mem_addr = (st == S_REQ1) ? slot_q + ADDR_W'(WORD_B) : slot_q;
  assign done     = done_q;
  assign lin_addr = lin_q;
  assign fault    = flt_q;
  assign rpl_out  = rpl_q;
  assign busy     = (st != S_IDLE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R4
  table_fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tab_fault_ev |=> (done && fault == 2'd1 && lin_addr == '0 && !mem_req));
  // R5
  seg_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fault_ev |=> (done && fault == 2'd2 && lin_addr == '0));
  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !fin_ev) |=> busy);
  // R6
  fault_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault != 2'd3));
endmodule

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] selector = 0;
  logic [31:0] offset = 0;
  logic [47:0] gdt_reg, ldt_reg;
  logic        mem_req, mem_rvalid = 0, done, busy;
  logic [31:0] mem_addr, mem_rdata = 0, lin_addr;
  logic [1:0]  fault, rpl_out;

  int checks = 0, errors = 0;
  int reqs = 0, dones = 0, pushed = 0;
  bit finished = 0;

  typedef struct {logic [31:0] lin; logic [1:0] flt; logic [1:0] rpl; string tag;} exp_t;
  exp_t sb[$];
  logic [31:0] mem [int unsigned];

  always #2 clk = ~clk;   // 250 MHz

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n), .start(start), .selector(selector), .offset(offset),
    .gdt_reg(gdt_reg), .ldt_reg(ldt_reg), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .lin_addr(lin_addr),
    .fault(fault), .rpl_out(rpl_out), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'hDEAD_BEEF;
  endfunction

  function automatic exp_t model(input logic [15:0] s, input logic [31:0] o, input string tag);
    exp_t e;
    logic [47:0] t;
    logic [31:0] tb, da, lo;
    logic [15:0] tl;
    t  = s[2] ? ldt_reg : gdt_reg;
    tb = t[47:16];
    tl = t[15:0];
    e.rpl = s[1:0];
    e.tag = tag;
    if ({16'd0, s[15:3], 3'b111} > {16'd0, tl}) begin
      e.flt = 2'd1; e.lin = 0;
    end else begin
      da = tb + {16'd0, s[15:3], 3'b000};
      lo = rd(da);
      if (o > {16'd0, lo[15:0]}) begin e.flt = 2'd2; e.lin = 0; end
      else begin e.flt = 2'd0; e.lin = rd(da + 4) + o; end
    end
    return e;
  endfunction

  // memory agent: variable latency, checks the read pair order (R3)
  initial begin
    logic [31:0] first = 0;
    bit second = 0;
    forever begin
      @(posedge clk);
      if (rst_n && mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        reqs++;
        if (second) chk("R3 second word address", a, first + 4);
        else begin chk("R3 slot alignment", {29'd0, a[2:0]}, 0); first = a; end
        second = !second;
        repeat (1 + reqs % 3) @(posedge clk);
        #1 mem_rvalid = 1; mem_rdata = rd(a);
        @(posedge clk);
        #1 mem_rvalid = 0;
      end
    end
  end

  // monitor: pops the scoreboard on every result
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      dones++;
      if (sb.size() == 0) chk("R7 unexpected result", 1, 0);
      else begin
        e = sb.pop_front();
        chk({e.tag, " lin_addr R6"}, lin_addr, e.lin);
        chk({e.tag, " fault R5"}, {30'd0, fault}, {30'd0, e.flt});
        chk({e.tag, " rpl_out R1"}, {30'd0, rpl_out}, {30'd0, e.rpl});
      end
    end
  end

  task automatic send(input logic [15:0] s, input logic [31:0] o, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    selector = s; offset = o; start = 1;
    sb.push_back(model(s, o, tag));
    pushed++;
    @(negedge clk);
    start = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy || sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    gdt_reg = {32'h0000_2000, 16'h00FF};
    ldt_reg = {32'h0000_2100, 16'h003F};
    mem[32'h2010] = 32'h0092_0FFF; mem[32'h2014] = 32'h0000_0100;  // global slot 2
    mem[32'h2120] = 32'h0092_001F; mem[32'h2124] = 32'h0010_0000;  // local slot 4
    mem[32'h2110] = 32'h0092_0000; mem[32'h2114] = 32'h0200_0000;  // local slot 2
    mem[32'h20F8] = 32'h0092_FFFF; mem[32'h20FC] = 32'hFFFF_FFF0;  // global slot 31

    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", {31'd0, done}, 0);
    chk("R9 mem_req", {31'd0, mem_req}, 0);
    chk("R9 busy", {31'd0, busy}, 0);
    chk("R9 fault", {30'd0, fault}, 0);
    chk("R9 lin_addr", lin_addr, 0);
    rst_n = 1;

    send(16'h0013, 32'h10, "R2 global");
    send(16'h0027, 32'h10, "R2 local");
    send(16'h0016, 32'h0, "R3 local slot 2");
    send(16'h0027, 32'h1F, "R5 at limit");
    send(16'h0027, 32'h20, "R5 past limit");
    send(16'h00F9, 32'h20, "R6 wrap");
    send(16'h0010, 32'h0FFF, "R6 global limit");
    drain();

    // R4: table overrun, one-cycle latency, no memory read
    begin
      int r0;
      r0 = reqs;
      @(negedge clk);
      selector = 16'h0102; offset = 0; start = 1;   // global slot 32, rpl 2
      sb.push_back(model(16'h0102, 0, "R4 global overrun"));
      pushed++;
      @(negedge clk);
      start = 0;
      chk("R4 done one cycle after start", {31'd0, done}, 1);
      chk("R4 fault code", {30'd0, fault}, 1);
      @(negedge clk);
      send(16'h0044, 32'h0, "R4 local overrun");    // local slot 8
      drain();
      repeat (4) @(negedge clk);
      chk("R4 no memory read", reqs, r0);
    end

    // R7: start while busy is ignored
    send(16'h0013, 32'h20, "R7 first");
    selector = 16'h0102; start = 1;
    @(negedge clk);
    start = 0;
    chk("R7 still busy", {31'd0, busy}, 1);
    drain();
    repeat (8) @(negedge clk);
    chk("R7 result count", dones, pushed);
    chk("R8 two reads per walk", {31'd0, reqs[0]}, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule